// File: doc/BRIEF.md
# Guarded Page Write Stager

This block sits behind a serial command slave in a byte-wide nonvolatile memory. The slave hands it four things: a start address when a write command opens, each complete data byte as it arrives, and pulses for the enable and disable commands. The block collects the bytes in a one-page staging buffer. A write that runs past the end of a page wraps back to the first byte of the same page.

When chip select returns high, the block decides whether to commit the page. Four checks must all pass: the write-protect pin is high, the write-enable latch is set, no staged byte lies in the selected protected region, and the frame ended on a byte boundary with at least one byte. If they pass, the block starts a self-timed program cycle and raises busy for a fixed number of clocks. During that cycle it copies the staged bytes into the array. When the cycle ends, it clears the enable latch.

After reset, a power-up delay must pass before any command or read is honoured. The array is a behavioural RAM with a registered read port.

Top module: `page_write_guard`

## Requirements
- R1: After reset, busy, wel and pwrReady are 0. pwrReady rises after PWRUP_CLKS clocks. Enable, write and read requests made before that have no effect.
- R2: A cmdWren pulse sets wel. A cmdWrdi pulse clears it. Both act from the next clock when the block is ready and not busy.
- R3: An accepted write raises busy in the clock after chip select rises. Busy then stays high for exactly CYCLE_CLKS clocks. Afterwards every staged byte reads back from its address. A read returns data one clock after rdEn.
- R4: wel falls in the same clock that busy falls at the end of a program cycle.
- R5: Bytes past the last offset of a PAGE_BYTES page wrap to offset 0 of the same page. A later byte overwrites an earlier byte at the same offset.
- R6: If wpN is low when chip select rises, the write is discarded. Busy stays low and the array is unchanged.
- R7: If wel is 0 when chip select rises, the write is discarded.
- R8: protSel selects the protected region. 0 = none. 1 = first page. 2 = last page. 3 to 6 = quarter 0 to 3, taken from the two top address bits. 7 = lower half, where the top address bit is 0. A write with any byte in the region is discarded. A write outside the region is committed.
- R9: If byteWhole is 0 at the chip-select rise, the write is discarded. A frame with no data bytes is also discarded.
- R10: While busy is high, cmdWren, cmdWrdi and complete write frames are ignored. Busy and wel remain observable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select from the serial slave, active low |
| cmdWren | input | 1 | Write-enable command pulse |
| cmdWrdi | input | 1 | Write-disable command pulse |
| cmdWrite | input | 1 | Write command pulse that carries the start address |
| cmdAddr | input | ADDR_W | Start address of the write |
| dataValid | input | 1 | One complete data byte is present |
| dataByte | input | 8 | Data byte |
| byteWhole | input | 1 | High when the slave's bit count is on a byte boundary |
| wpN | input | 1 | Hardware write protect, active low |
| protSel | input | 3 | Protected-region code |
| rdEn | input | 1 | Array read request |
| rdAddr | input | ADDR_W | Array read address |
| rdData | output | 8 | Registered read data |
| busy | output | 1 | Program cycle in progress |
| wel | output | 1 | Write-enable latch |
| pwrReady | output | 1 | Power-up delay has elapsed |

## Verification
A bad write offset or a broken wrap shows up at the read port. After the cycle, the wrong byte appears at an address, or an older byte survives where it should have been replaced. A stuck region comparator or a bad protection flag shows up either as a missing busy pulse or as an overwritten byte, one clock after chip select rises. A cycle timer off by even one count changes the busy pulse length. An enable latch that is not cleared shows up as wel still high in the clock after busy falls.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_PROG} ctlState_t;

  typedef struct packed {
    logic openSess;
    logic takeByte;
    logic commitStep;
  } pwgStrobe_t;

  typedef struct packed {
    logic anyByte;
    logic hitProt;
  } pwgFlags_t;

  localparam logic [2:0] PROT_NONE    = 3'd0;
  localparam logic [2:0] PROT_FIRST   = 3'd1;
  localparam logic [2:0] PROT_LAST    = 3'd2;
  localparam logic [2:0] PROT_LOWHALF = 3'd7;
endpackage

// File: rtl/pwg_ctrl.sv
module pwg_ctrl
  import pwg_pkg::*;
#(
  parameter int PAGE_BYTES = 64,
  parameter int CYCLE_CLKS = 80,
  parameter int PWRUP_CLKS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       cmdWren,
  input  logic       cmdWrdi,
  input  logic       cmdWrite,
  input  logic       dataValid,
  input  logic       byteWhole,
  input  logic       wpN,
  input  pwgFlags_t  flags,
  output pwgStrobe_t strobe,
  output logic       busy,
  output logic       wel,
  output logic       pwrReady
);
  // the cycle must be long enough to copy the whole page one byte per clock
  localparam int CYC_EFF = (CYCLE_CLKS < PAGE_BYTES) ? PAGE_BYTES : CYCLE_CLKS;
  localparam int PU_EFF  = (PWRUP_CLKS < 1) ? 1 : PWRUP_CLKS;
  localparam int CYC_W   = $clog2(CYC_EFF + 1);
  localparam int PU_W    = $clog2(PU_EFF + 1);

  ctlState_t        state;
  logic [CYC_W-1:0] cycCnt;
  logic [PU_W-1:0]  pwrCnt;
  logic             csPrev;
  logic             csRise;
  logic             cycLast;
  logic             startOk;

  assign csRise  = csN & ~csPrev;
  assign cycLast = (cycCnt == CYC_W'(CYC_EFF - 1));
  assign startOk = wpN & wel & byteWhole & flags.anyByte & ~flags.hitProt;
  assign busy    = (state == ST_PROG);

  always_comb begin
    strobe            = '0;
    strobe.openSess   = (state == ST_IDLE) && cmdWrite && pwrReady;
    strobe.takeByte   = (state == ST_COLLECT) && dataValid;
    strobe.commitStep = (state == ST_PROG) && (32'(cycCnt) < PAGE_BYTES);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrCnt   <= '0;
      pwrReady <= 1'b0;
    end else if (!pwrReady) begin
      if (pwrCnt == PU_W'(PU_EFF - 1)) pwrReady <= 1'b1;
      else pwrCnt <= pwrCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cycCnt <= '0;
      csPrev <= 1'b1;
    end else begin
      csPrev <= csN;
      case (state)
        ST_IDLE: begin
          if (cmdWrite && pwrReady) state <= ST_COLLECT;
        end
        ST_COLLECT: begin
          cycCnt <= '0;
          if (csRise) state <= startOk ? ST_PROG : ST_IDLE;
        end
        ST_PROG: begin
          if (cycLast) state <= ST_IDLE;
          else cycCnt <= cycCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel <= 1'b0;
    end else if (busy) begin
      if (cycLast) wel <= 1'b0;
    end else if (pwrReady) begin
      if (cmdWrdi) wel <= 1'b0;
      else if (cmdWren) wel <= 1'b1;
    end
  end
endmodule

// File: rtl/pwg_datapath.sv
module pwg_datapath
  import pwg_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwgStrobe_t        strobe,
  input  logic [2:0]        protSel,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        dataByte,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              pwrReady,
  output pwgFlags_t         flags,
  output logic [7:0]        rdData
);
  localparam int PG_W  = $clog2(PAGE_BYTES);
  localparam int PN_W  = ADDR_W - PG_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PN_W-1:0]       pageBase;
  logic [PG_W-1:0]       wrOff;
  logic [PG_W-1:0]       cmtPtr;
  logic [PAGE_BYTES-1:0] byteVld;
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [7:0]            memArr  [DEPTH];
  logic                  wrHit;

  function automatic logic inRegion(input logic [ADDR_W-1:0] a, input logic [2:0] sel);
    logic [PN_W-1:0] pg;
    pg = a[ADDR_W-1:PG_W];
    case (sel)
      PROT_NONE:    return 1'b0;
      PROT_FIRST:   return pg == '0;
      PROT_LAST:    return pg == '1;
      PROT_LOWHALF: return ~a[ADDR_W-1];
      default:      return a[ADDR_W-1:ADDR_W-2] == 2'(sel - 3'd3);
    endcase
  endfunction

  assign wrHit = inRegion({pageBase, wrOff}, protSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageBase <= '0;
      wrOff    <= '0;
      cmtPtr   <= '0;
      byteVld  <= '0;
      flags    <= '0;
    end else if (strobe.openSess) begin
      pageBase <= cmdAddr[ADDR_W-1:PG_W];
      wrOff    <= cmdAddr[PG_W-1:0];
      cmtPtr   <= '0;
      byteVld  <= '0;
      flags    <= '0;
    end else begin
      if (strobe.takeByte) begin
        byteVld[wrOff] <= 1'b1;
        wrOff          <= wrOff + 1'b1;
        flags.anyByte  <= 1'b1;
        if (wrHit) flags.hitProt <= 1'b1;
      end
      if (strobe.commitStep) cmtPtr <= cmtPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.takeByte) pageBuf[wrOff] <= dataByte;
  end

  always_ff @(posedge clk) begin
    if (strobe.commitStep && byteVld[cmtPtr]) memArr[{pageBase, cmtPtr}] <= pageBuf[cmtPtr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (rdEn && pwrReady) rdData <= memArr[rdAddr];
  end
endmodule

// File: rtl/page_write_guard.sv
module page_write_guard
  import pwg_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 64,
  parameter int CYCLE_CLKS = 80,
  parameter int PWRUP_CLKS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              cmdWren,
  input  logic              cmdWrdi,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              dataValid,
  input  logic [7:0]        dataByte,
  input  logic              byteWhole,
  input  logic              wpN,
  input  logic [2:0]        protSel,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              busy,
  output logic              wel,
  output logic              pwrReady
);
  pwgStrobe_t strobe;
  pwgFlags_t  flags;

  pwg_ctrl #(
    .PAGE_BYTES(PAGE_BYTES), .CYCLE_CLKS(CYCLE_CLKS), .PWRUP_CLKS(PWRUP_CLKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .cmdWren(cmdWren), .cmdWrdi(cmdWrdi),
    .cmdWrite(cmdWrite), .dataValid(dataValid), .byteWhole(byteWhole), .wpN(wpN),
    .flags(flags), .strobe(strobe), .busy(busy), .wel(wel), .pwrReady(pwrReady)
  );

  pwg_datapath #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .protSel(protSel), .cmdAddr(cmdAddr),
    .dataByte(dataByte), .rdEn(rdEn), .rdAddr(rdAddr), .pwrReady(pwrReady),
    .flags(flags), .rdData(rdData)
  );
endmodule

// File: rtl/pwg_checker.sv
module pwg_checker (
  input logic clk,
  input logic rstN,
  input logic wpN,
  input logic byteWhole,
  input logic busy,
  input logic wel,
  input logic pwrReady
);
  // R1
  powerup_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pwrReady |-> (!busy && !wel));

  // R4
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wel);

  // R6
  wp_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wpN));

  // R9
  whole_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(byteWhole));

  // R7
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wel));

  // R10
  busy_keeps_wel_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> wel);
endmodule

bind page_write_guard pwg_checker u_chk (
  .clk(clk), .rstN(rstN), .wpN(wpN), .byteWhole(byteWhole),
  .busy(busy), .wel(wel), .pwrReady(pwrReady)
);

// File: tb/test_page_write_guard.sv
module test_page_write_guard;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int PB = 64;
  localparam int CYC = 80;
  localparam int PWU = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, cmdWren = 1'b0, cmdWrdi = 1'b0, cmdWrite = 1'b0;
  logic [AW-1:0] cmdAddr = '0, rdAddr = '0;
  logic dataValid = 1'b0, byteWhole = 1'b1, wpN = 1'b1, rdEn = 1'b0;
  logic [7:0] dataByte = '0;
  logic [2:0] protSel = 3'd0;
  logic [7:0] rdData;
  logic busy, wel, pwrReady;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  typedef struct {
    logic [AW-1:0] a;
    logic [7:0]    d;
    string         tag;
  } exp_t;
  exp_t sbQ[$];
  logic rdSeen = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  page_write_guard #(
    .ADDR_W(AW), .PAGE_BYTES(PB), .CYCLE_CLKS(CYC), .PWRUP_CLKS(PWU)
  ) i_page_write_guard (
    .clk(clk), .rstN(rstN), .csN(csN), .cmdWren(cmdWren), .cmdWrdi(cmdWrdi),
    .cmdWrite(cmdWrite), .cmdAddr(cmdAddr), .dataValid(dataValid), .dataByte(dataByte),
    .byteWhole(byteWhole), .wpN(wpN), .protSel(protSel), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .busy(busy), .wel(wel), .pwrReady(pwrReady)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: a read issued before the last edge is due now
  always @(posedge clk) rdSeen <= rdEn;
  always @(negedge clk) begin
    if (rdSeen) begin
      if (sbQ.size() == 0) check(1'b0, "R3 unexpected read", int'(rdData), 0);
      else begin
        exp_t e;
        e = sbQ.pop_front();
        check(rdData === e.d, e.tag, int'(rdData), int'(e.d));
      end
    end
  end

  task automatic readExpect(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
    exp_t e;
    e.a = a; e.d = d; e.tag = tag;
    sbQ.push_back(e);
    rdEn = 1'b1; rdAddr = a;
    tick();
    rdEn = 1'b0;
    tick();
  endtask

  task automatic pulseWren();
    cmdWren = 1'b1; tick(); cmdWren = 1'b0; tick();
  endtask

  task automatic pulseWrdi();
    cmdWrdi = 1'b1; tick(); cmdWrdi = 1'b0; tick();
  endtask

  // ends at the falling edge after the clock that sees chip select rise
  task automatic writeBurst(input logic [AW-1:0] a, input int n, input logic [7:0] seed,
                            input bit whole);
    csN = 1'b0; cmdWrite = 1'b1; cmdAddr = a;
    tick();
    cmdWrite = 1'b0;
    for (int i = 0; i < n; i++) begin
      dataValid = 1'b1; dataByte = seed + 8'(i);
      tick();
    end
    dataValid = 1'b0; byteWhole = whole;
    tick();
    csN = 1'b1;
    tick();
    byteWhole = 1'b1;
  endtask

  task automatic waitIdle(output int cnt);
    cnt = 0;
    while (busy && cnt < 4 * CYC) begin
      cnt++;
      tick();
    end
  endtask

  initial begin
    int n;
    tick(3);
    check(busy == 1'b0 && wel == 1'b0 && pwrReady == 1'b0, "R1 reset state",
          {busy, wel, pwrReady}, 0);
    rstN = 1'b1;
    pulseWren();
    check(wel == 1'b0, "R1 enable before ready", wel, 0);
    check(pwrReady == 1'b0, "R1 not yet ready", pwrReady, 0);
    tick(PWU);
    check(pwrReady == 1'b1, "R1 ready after delay", pwrReady, 1);

    // R2
    pulseWren();
    check(wel == 1'b1, "R2 enable sets", wel, 1);
    pulseWrdi();
    check(wel == 1'b0, "R2 disable clears", wel, 0);

    // R3 basic write and R4
    pulseWren();
    writeBurst(10'h085, 4, 8'h10, 1'b1);
    check(busy == 1'b1, "R3 busy after cs rise", busy, 1);
    waitIdle(n);
    check(n == CYC, "R3 busy length", n, CYC);
    check(wel == 1'b0, "R4 wel cleared at end", wel, 0);
    for (int i = 0; i < 4; i++) readExpect(10'h085 + 10'(i), 8'h10 + 8'(i), "R3 readback");

    // R5 wrap inside page 2
    pulseWren();
    writeBurst(10'h0BE, 4, 8'h40, 1'b1);
    waitIdle(n);
    readExpect(10'h0BE, 8'h40, "R5 tail byte");
    readExpect(10'h0BF, 8'h41, "R5 last offset");
    readExpect(10'h080, 8'h42, "R5 wrapped offset 0");
    readExpect(10'h081, 8'h43, "R5 wrapped offset 1");

    // R6 write protect pin
    pulseWren();
    wpN = 1'b0;
    writeBurst(10'h085, 2, 8'h70, 1'b1);
    check(busy == 1'b0, "R6 no cycle under wp", busy, 0);
    check(wel == 1'b1, "R6 wel kept", wel, 1);
    wpN = 1'b1;
    readExpect(10'h085, 8'h10, "R6 array unchanged");

    // R7 no enable
    pulseWrdi();
    writeBurst(10'h086, 1, 8'h77, 1'b1);
    check(busy == 1'b0, "R7 no cycle without wel", busy, 0);
    readExpect(10'h086, 8'h11, "R7 array unchanged");

    // R9 partial byte and empty frame
    pulseWren();
    writeBurst(10'h087, 1, 8'h55, 1'b0);
    check(busy == 1'b0, "R9 partial byte cancels", busy, 0);
    writeBurst(10'h087, 0, 8'h55, 1'b1);
    check(busy == 1'b0, "R9 empty frame cancels", busy, 0);
    readExpect(10'h087, 8'h12, "R9 array unchanged");

    // R8 protected regions
    protSel = 3'd3;
    writeBurst(10'h085, 2, 8'h60, 1'b1);
    check(busy == 1'b0, "R8 quarter 0 blocks", busy, 0);
    protSel = 3'd1;
    writeBurst(10'h003, 1, 8'h61, 1'b1);
    check(busy == 1'b0, "R8 first page blocks", busy, 0);
    protSel = 3'd2;
    writeBurst(10'h3C0, 1, 8'h62, 1'b1);
    check(busy == 1'b0, "R8 last page blocks", busy, 0);
    protSel = 3'd7;
    writeBurst(10'h100, 1, 8'h63, 1'b1);
    check(busy == 1'b0, "R8 lower half blocks", busy, 0);
    readExpect(10'h085, 8'h10, "R8 array unchanged");
    protSel = 3'd4;
    writeBurst(10'h085, 2, 8'h90, 1'b1);
    check(busy == 1'b1, "R8 other quarter passes", busy, 1);
    waitIdle(n);
    readExpect(10'h085, 8'h90, "R8 committed byte 0");
    readExpect(10'h086, 8'h91, "R8 committed byte 1");

    // R10 commands during busy
    protSel = 3'd0;
    pulseWren();
    writeBurst(10'h200, 1, 8'h20, 1'b1);
    check(busy == 1'b1, "R10 cycle started", busy, 1);
    pulseWrdi();
    check(wel == 1'b1, "R10 disable ignored while busy", wel, 1);
    writeBurst(10'h085, 2, 8'hAA, 1'b1);
    check(busy == 1'b1, "R10 busy still visible", busy, 1);
    waitIdle(n);
    tick(3);
    check(busy == 1'b0, "R10 no cycle from ignored frame", busy, 0);
    readExpect(10'h085, 8'h90, "R10 ignored frame left array");
    readExpect(10'h200, 8'h20, "R10 first write committed");

    tick(2);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule